// File: doc/BRIEF.md
# Dual-Lane SPI Master

This block is a serial peripheral master with one shift engine and three data modes. In single mode it runs an ordinary full-duplex exchange on lane 0. In paired mode two lanes shift at the same moment under one serial clock and one select line. Lane 0 carries the first word and lane 1 the following word, so two devices can be served in a single frame. In wide mode both data pads carry one word at two bits per clock. Software picks the direction: the master either drives the word out or reads it in.

The host loads a control word and one or two transmit words, then pulses `start`. While the frame runs the host watches `busy`. A one-cycle `done` pulse marks the end, and the receive words can then be read. The serial clock idles low: data changes on its falling edge and is sampled on its rising edge. The clock rate comes from a divider in the control word.

Top module: `duo_spi_master`

## Requirements
- R1: After reset and whenever idle: `ss_n`=1, `sclk`=0, `busy`=0, `done`=0 and `sd_oe`=00.
- R2: `start` sampled high while idle begins a frame on that clock edge: `ss_n` goes low and `busy` goes high. One half-period is DIV+1 clock cycles, where DIV=`ctrl[15:8]`. The first rising `sclk` comes one half-period after `ss_n` falls. With B serial clocks per word, the frame lasts (2B+1)(DIV+1) cycles from the start edge to the edge that raises `ss_n`.
- R3: `ctrl[1:0]` sets the word length: 00=8, 01=16, 10=24, 11=32 bits. Words sit in the low bits of the 32-bit ports and shift MSB first. Transmit bits above the length are never sent. Receive words hold zero above the length.
- R4: Single mode (`ctrl[21]`=0, `ctrl[16]`=0): `tx_word0` goes out on `sd_o[0]` with `sd_oe`=01. The word is sampled from `miso_i[0]` into `rx_word0`, with B = length. `rx_word1` reads zero.
- R5: Paired mode (`ctrl[21]`=0, `ctrl[16]`=1): `tx_word0` on `sd_o[0]` and `tx_word1` on `sd_o[1]` shift on the same clocks, with `sd_oe`=11. `miso_i[0]` and `miso_i[1]` are captured at the same time into `rx_word0` and `rx_word1`.
- R6: Wide mode (`ctrl[21]`=1, which overrides `ctrl[16]`): each serial clock carries two bits, the higher on pad 1 and the next on pad 0, so B = length/2.
- R7: Wide mode with `ctrl[20]`=1 drives the word from `tx_word0` with `sd_oe`=11. Both receive words read zero.
- R8: Wide mode with `ctrl[20]`=0 keeps `sd_oe`=00 for the whole frame. The word is assembled from `sd_i` into `rx_word0`, and `rx_word1` reads zero.
- R9: `ss_n` rises DIV+1 cycles after the last falling `sclk` edge. `done` is high for exactly the one cycle in which `ss_n` has just risen.
- R10: Changes to `ctrl`, the transmit words or `start` while `busy` have no effect on the running frame.
- R11: A `start` held high through the `done` cycle starts the next frame on the following edge, so `ss_n` stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl | input | 32 | Control: [21] wide mode, [20] wide direction (1=out), [16] paired mode, [15:8] divider, [1:0] length |
| tx_word0 | input | 32 | Transmit word for lane 0 or the wide word |
| tx_word1 | input | 32 | Transmit word for lane 1 (paired mode) |
| start | input | 1 | Start request, taken only when idle |
| rx_word0 | output | 32 | Receive word from lane 0 or the wide word |
| rx_word1 | output | 32 | Receive word from lane 1 |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| sclk | output | 1 | Serial clock, idles low |
| ss_n | output | 1 | Slave select, active low |
| sd_o | output | 2 | Data pad output values |
| sd_oe | output | 2 | Data pad output enables |
| sd_i | input | 2 | Data pad input values (used in wide receive) |
| miso_i | input | 2 | Per-lane serial inputs (single and paired modes) |

## Verification
The end of one frame and a new start request can fall in the same cycle. The end of a frame also overlaps with control writes made while the frame runs. The bench holds `start` high through a whole frame. It then checks that the held request neither lengthened nor restarted that frame, and that the request was honoured on the edge right after the `done` pulse, with `ss_n` high for one cycle only. A second collision rewrites the control word, the transmit word and `start` in the middle of a slow frame. That frame must still finish with its original bits, length and duration.

// File: rtl/duo_spi_pkg.sv
// Shared types and control-word field positions for the dual-lane SPI master.
// Assumes a 32-bit control word and transmit/receive words of 32 bits.
package duo_spi_pkg;
    localparam int CTL_WIDE_BIT = 21;
    localparam int CTL_DIR_BIT  = 20;
    localparam int CTL_PAIR_BIT = 16;
    localparam int CTL_DIV_LSB  = 8;
    localparam int DIV_W        = 8;

    typedef enum logic [1:0] {
        XFER_SINGLE = 2'd0,
        XFER_PAIR   = 2'd1,
        XFER_WIDE   = 2'd2
    } xfer_mode_e;

    typedef struct packed {
        xfer_mode_e mode;
        logic       drive_out;
        logic [1:0] len;
    } xfer_cfg_t;

    // Word length in bits for a 2-bit length code (8, 16, 24 or 32).
    function automatic logic [5:0] word_bits(input logic [1:0] len);
        return 6'(({4'd0, len} + 6'd1) << 3);
    endfunction
endpackage

// File: rtl/duo_spi_tick.sv
// Half-period tick generator: while run is high, pulses tick once every
// div+1 clock cycles. The count restarts from zero whenever run is low.
module duo_spi_tick #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    // Count cycles within one half-period of the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/duo_spi_lane.sv
// One shift lane: an MSB-aligned transmit register and an LSB-filled receive
// register. In wide mode both registers move two bits per step.
// Assumes the caller never steps transmit and receive in the same cycle.
module duo_spi_lane #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         tx_step,
    input  logic         rx_step,
    input  logic         wide,
    input  logic [1:0]   sin,
    output logic [1:0]   top,
    output logic [W-1:0] rx_word
);
    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    assign top     = tx_q[W-1:W-2];
    assign rx_word = rx_q;

    // Transmit shifter: load on start, advance on each falling serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_q <= '0;
        else if (load)    tx_q <= load_word;
        else if (tx_step) tx_q <= wide ? {tx_q[W-3:0], 2'b00} : {tx_q[W-2:0], 1'b0};
    end

    // Receive shifter: clear on start, take new bits on each rising serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n || load) rx_q <= '0;
        else if (rx_step)   rx_q <= wide ? {rx_q[W-3:0], sin} : {rx_q[W-2:0], sin[0]};
    end

    // R4: data changes and sampling never share a cycle.
    assert_step_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_step && rx_step));
    // R2: a new frame never shifts in its loading cycle.
    assert_load_no_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !tx_step && !rx_step);
endmodule

// File: rtl/duo_spi_master.sv
// Dual-lane SPI master, serial clock idle low. Latches the control and
// transmit words on an accepted start, runs a frame of 2B+1 half-periods,
// and steers two lane shifters to the pads by mode.
// Assumes WORD_W >= 32 so that every length code fits.
module duo_spi_master
    import duo_spi_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       ctrl,
    input  logic [WORD_W-1:0] tx_word0,
    input  logic [WORD_W-1:0] tx_word1,
    input  logic              start,
    output logic [WORD_W-1:0] rx_word0,
    output logic [WORD_W-1:0] rx_word1,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              ss_n,
    output logic [1:0]        sd_o,
    output logic [1:0]        sd_oe,
    input  logic [1:0]        sd_i,
    input  logic [1:0]        miso_i
);
    localparam int HP_W  = $clog2(2 * WORD_W + 2);
    localparam int SH_W  = $clog2(WORD_W + 1);
    localparam int LANES = 2;

    xfer_cfg_t          cfg_d, cfg_q;
    logic [5:0]         nbits_d;
    logic [HP_W-1:0]    last_hp_d, last_hp_q, hp_q;
    logic [SH_W-1:0]    align_sh;
    logic [DIV_W-1:0]   div_q;
    logic               busy_q, ss_n_q, sclk_q, done_q;
    logic               tick, accept, at_end, rx_step, tx_step, wide_q;
    logic [1:0]         oe_raw, dat_raw;
    logic [1:0]         lane_top  [LANES];
    logic [WORD_W-1:0]  lane_rx   [LANES];
    logic [WORD_W-1:0]  lane_load [LANES];
    logic [1:0]         lane_sin  [LANES];
    logic               lane_rx_en[LANES];
    logic               ctrl_unused;

    // Decode the control word presented at start.
    always_comb begin
        cfg_d.mode      = ctrl[CTL_WIDE_BIT] ? XFER_WIDE
                        : (ctrl[CTL_PAIR_BIT] ? XFER_PAIR : XFER_SINGLE);
        cfg_d.drive_out = ctrl[CTL_DIR_BIT];
        cfg_d.len       = ctrl[1:0];
        nbits_d         = word_bits(ctrl[1:0]);
        last_hp_d       = (cfg_d.mode == XFER_WIDE) ? HP_W'(nbits_d) : HP_W'({nbits_d, 1'b0});
        align_sh        = SH_W'(WORD_W) - SH_W'(nbits_d);
    end

    assign accept  = start && !busy_q;
    assign at_end  = (hp_q == last_hp_q);
    assign rx_step = tick && !at_end && !hp_q[0];
    assign tx_step = tick && !at_end && hp_q[0] && ((hp_q + HP_W'(1)) != last_hp_q);
    assign wide_q  = (cfg_q.mode == XFER_WIDE);

    duo_spi_tick #(.DW(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy_q),
        .div  (div_q),
        .tick (tick)
    );

    // Hold the frame configuration from start until the frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            div_q     <= '0;
            last_hp_q <= '0;
        end else if (accept) begin
            cfg_q     <= cfg_d;
            div_q     <= ctrl[CTL_DIV_LSB +: DIV_W];
            last_hp_q <= last_hp_d;
        end
    end

    // Frame sequencer: select, half-period count, serial clock and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ss_n_q <= 1'b1;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
            hp_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                ss_n_q <= 1'b0;
                hp_q   <= '0;
            end else if (tick) begin
                if (at_end) begin
                    busy_q <= 1'b0;
                    ss_n_q <= 1'b1;
                    done_q <= 1'b1;
                end else begin
                    hp_q   <= hp_q + HP_W'(1);
                    sclk_q <= !hp_q[0];
                end
            end
        end
    end

    assign lane_load[0]  = tx_word0 << align_sh;
    assign lane_load[1]  = tx_word1 << align_sh;
    assign lane_sin[0]   = wide_q ? sd_i : {1'b0, miso_i[0]};
    assign lane_sin[1]   = {1'b0, miso_i[1]};
    assign lane_rx_en[0] = !(wide_q && cfg_q.drive_out);
    assign lane_rx_en[1] = (cfg_q.mode == XFER_PAIR);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        duo_spi_lane #(.W(WORD_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (accept),
            .load_word(lane_load[k]),
            .tx_step  (tx_step),
            .rx_step  (rx_step && lane_rx_en[k]),
            .wide     (wide_q),
            .sin      (lane_sin[k]),
            .top      (lane_top[k]),
            .rx_word  (lane_rx[k])
        );
    end

    // Steer lane outputs and enables to the two pads by mode.
    always_comb begin
        unique case (cfg_q.mode)
            XFER_WIDE: begin
                oe_raw  = cfg_q.drive_out ? 2'b11 : 2'b00;
                dat_raw = lane_top[0];
            end
            XFER_PAIR: begin
                oe_raw  = 2'b11;
                dat_raw = {lane_top[1][1], lane_top[0][1]};
            end
            default: begin
                oe_raw  = 2'b01;
                dat_raw = {1'b0, lane_top[0][1]};
            end
        endcase
    end

    assign sd_oe    = busy_q ? oe_raw : 2'b00;
    assign sd_o     = dat_raw & sd_oe;
    assign rx_word0 = lane_rx[0];
    assign rx_word1 = lane_rx[1];
    assign busy     = busy_q;
    assign done     = done_q;
    assign sclk     = sclk_q;
    assign ss_n     = ss_n_q;

    assign ctrl_unused = ^{ctrl[31:22], ctrl[19:17], ctrl[7:2], lane_top[1][0]};

    // R1: idle means select high, clock low, pads released.
    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ss_n && !sclk && (sd_oe == 2'b00));
    // R9: done lasts one cycle.
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: done coincides with the select having just risen.
    assert_done_on_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ss_n && $past(!ss_n));
    // R9: select only rises with the serial clock already low.
    assert_clk_low_at_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n) |-> !sclk);
    // R10: configuration stays frozen through a frame.
    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(cfg_q) && $stable(div_q));
    // R8: wide receive never drives the pads.
    assert_wide_in_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (cfg_q.mode == XFER_WIDE) && !cfg_q.drive_out |-> sd_oe == 2'b00);
endmodule

// File: tb/tb_duo_spi_master.sv
`timescale 1ns/1ps
// Self-checking bench: a table of frames walked by one loop with a slave
// model, then directed tests for reset, mid-frame writes and held start.
module tb_duo_spi_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl = '0, tx_word0 = '0, tx_word1 = '0;
    logic        start = 1'b0;
    logic [31:0] rx_word0, rx_word1;
    logic        busy, done, sclk, ss_n;
    logic [1:0]  sd_o, sd_oe, sd_i, miso_i = 2'b00, drv = 2'b00;

    int checks = 0, failures = 0;
    int cyc = 0, t_start = 0, t_done = 0, t_fall = 0;
    logic busy_d = 1'b0, sclk_d = 1'b0;
    logic [31:0] cap0, cap1;
    int oe_bad;

    always #2.5 clk = ~clk;

    assign sd_i = {sd_oe[1] ? sd_o[1] : drv[1], sd_oe[0] ? sd_o[0] : drv[0]};

    duo_spi_master dut (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .tx_word0(tx_word0), .tx_word1(tx_word1),
        .start(start), .rx_word0(rx_word0), .rx_word1(rx_word1), .busy(busy), .done(done),
        .sclk(sclk), .ss_n(ss_n), .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i), .miso_i(miso_i)
    );

    // Timestamp frame start, last falling serial edge and done, on falling clk.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (busy && !busy_d) t_start = cyc;
        if (sclk_d && !sclk) t_fall = cyc;
        if (done) t_done = cyc;
        busy_d = busy;
        sclk_d = sclk;
    end

    localparam int NV = 8;
    localparam logic [31:0] V_CTRL [NV] = '{
        32'h0000_0000, 32'h0000_0203, 32'h0001_0101, 32'h0001_0002,
        32'h0030_0103, 32'h0020_0001, 32'h0031_0300, 32'h0020_0202 };
    localparam logic [31:0] V_TX0 [NV] = '{
        32'hFFFF_FFA5, 32'h8123_4567, 32'hEEEE_1234, 32'h00C0_FFEE,
        32'hDEAD_BEEF, 32'h0000_FFFF, 32'h1234_56B7, 32'hFFFF_FFFF };
    localparam logic [31:0] V_TX1 [NV] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'h5555_ABCD, 32'hFF3C_A596,
        32'h0F0F_0F0F, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'h0000_0000 };
    localparam logic [31:0] V_SL0 [NV] = '{
        32'h0000_003C, 32'hF00D_CAFE, 32'h0000_5A5A, 32'h0081_7E01,
        32'h1357_9BDF, 32'h0000_B00C, 32'h0000_0066, 32'h00A5_C381 };
    localparam logic [31:0] V_SL1 [NV] = '{
        32'h0000_00FF, 32'h0000_0000, 32'h0000_C3C3, 32'h0024_6801,
        32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000 };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present slave bits for serial clock i.
    task automatic set_slave(input bit wide, input int nb, input int i,
                             input logic [31:0] s0, input logic [31:0] s1);
        if (wide) begin
            drv    = s0[nb-1-2*i -: 2];
            miso_i = 2'b00;
        end else begin
            drv    = 2'b00;
            miso_i = {s1[nb-1-i], s0[nb-1-i]};
        end
    endtask

    // Run one frame as the slave; meddle rewrites inputs mid-frame (R10).
    task automatic do_frame(input logic [31:0] c, input logic [31:0] t0, input logic [31:0] t1,
                            input logic [31:0] s0, input logic [31:0] s1, input bit meddle,
                            output int nb, output int clks);
        bit wide = c[21];
        logic [1:0] exp_oe;
        nb   = 8 * (int'(c[1:0]) + 1);
        clks = wide ? nb / 2 : nb;
        exp_oe = wide ? (c[20] ? 2'b11 : 2'b00) : (c[16] ? 2'b11 : 2'b01);
        cap0 = '0; cap1 = '0; oe_bad = 0;
        set_slave(wide, nb, 0, s0, s1);
        @(negedge clk);
        ctrl = c; tx_word0 = t0; tx_word1 = t1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < clks; i++) begin
            @(posedge sclk);
            #1;
            if (sd_oe !== exp_oe) oe_bad++;
            if (wide) cap0 = {cap0[29:0], sd_o[1], sd_o[0]};
            else begin
                cap0 = {cap0[30:0], sd_o[0]};
                cap1 = {cap1[30:0], sd_o[1]};
            end
            if (meddle && i == 0) begin
                @(negedge clk);
                ctrl = 32'h0031_0003; tx_word0 = 32'h0; tx_word1 = 32'hFFFF_FFFF; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            @(negedge sclk);
            #1;
            if (i + 1 < clks) set_slave(wide, nb, i + 1, s0, s1);
        end
        wait (done === 1'b1);
        @(negedge clk);
        @(negedge clk);
        #1;
    endtask

    function automatic logic [31:0] lmask(input int nb);
        return (nb == 32) ? 32'hFFFF_FFFF : ((32'h1 << nb) - 32'h1);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int nb, clks, dv;
        logic [31:0] c, m;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ss_n", 32'(ss_n), 32'd1);
        chk("R1 sclk", 32'(sclk), 32'd0);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 sd_oe", 32'(sd_oe), 32'd0);

        for (int v = 0; v < NV; v++) begin
            c = V_CTRL[v];
            do_frame(c, V_TX0[v], V_TX1[v], V_SL0[v], V_SL1[v], 1'b0, nb, clks);
            m  = lmask(nb);
            dv = int'(c[15:8]);
            // R2 frame duration, R9 release spacing and done pulse width
            chk("R2 duration", 32'(t_done - t_start), 32'((2 * clks + 1) * (dv + 1)));
            chk("R9 release after last fall", 32'(t_done - t_fall), 32'(dv + 1));
            chk("R9 done one cycle", 32'({done, ss_n}), 32'b01);
            if (c[21] && c[20]) begin
                // R6 two bits per clock, R7 wide out
                chk("R6 R7 wide tx bits", cap0, V_TX0[v] & m);
                chk("R7 rx_word0 zero", rx_word0, 32'h0);
                chk("R7 oe", 32'(oe_bad), 32'd0);
            end else if (c[21]) begin
                chk("R6 R8 wide rx word", rx_word0, V_SL0[v] & m);
                chk("R8 oe released", 32'(oe_bad), 32'd0);
                chk("R8 rx_word1 zero", rx_word1, 32'h0);
            end else if (c[16]) begin
                chk("R5 R3 lane0 tx", cap0, V_TX0[v] & m);
                chk("R5 lane1 tx", cap1, V_TX1[v] & m);
                chk("R5 lane0 rx", rx_word0, V_SL0[v] & m);
                chk("R5 lane1 rx", rx_word1, V_SL1[v] & m);
                chk("R5 oe", 32'(oe_bad), 32'd0);
            end else begin
                chk("R4 R3 tx", cap0, V_TX0[v] & m);
                chk("R4 R3 rx", rx_word0, V_SL0[v] & m);
                chk("R4 rx_word1 zero", rx_word1, 32'h0);
                chk("R4 oe", 32'(oe_bad), 32'd0);
            end
        end

        // R10: mid-frame writes to ctrl, tx and start leave the frame unchanged
        do_frame(32'h0000_0300, 32'h0000_0096, 32'h0, 32'h0000_0069, 32'h0, 1'b1, nb, clks);
        chk("R10 tx kept", cap0, 32'h96);
        chk("R10 rx kept", rx_word0, 32'h69);
        chk("R10 duration kept", 32'(t_done - t_start), 32'(17 * 4));
        chk("R10 no restart", 32'({busy, ss_n}), 32'b01);

        // R11: start held through the done cycle
        drv = 2'b00; miso_i = 2'b00;
        @(negedge clk);
        ctrl = 32'h0; tx_word0 = 32'h0000_00C3; start = 1'b1;
        wait (done === 1'b1);
        @(negedge clk);
        #1;
        chk("R10 held start ignored while busy", 32'(t_done - t_start), 32'd17);
        @(negedge clk);
        #1;
        chk("R11 restart next edge", 32'({ss_n, busy, done}), 32'b010);
        start = 1'b0;
        wait (done === 1'b1);
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R11 second frame ends idle", 32'({ss_n, busy}), 32'b10);
        chk("R1 idle pads", 32'(sd_oe), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule